// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block keeps the exception state of a floating-point unit. On every clock it receives five raw condition flags from the arithmetic datapath (invalid, divide-by-zero, overflow, underflow, inexact) and an optional per-operation cause event naming one of eight causes. From these it maintains two bytes of a status word: a per-operation cause byte, in which only the most recent cause is recorded, and a sticky accrued byte that collects datapath flags until software clears them. A 16-bit control word holds one trap enable per cause, aligned bit for bit with the cause byte.

When a cause is raised and its enable bit is set, the block emits a one-cycle trap request together with an 8-bit exception vector number. Software loads the status word or the control word through a single write port. A status write has priority over everything else in that cycle. It also reloads the sticky datapath flags from the accrued bits that were written, so later flags accumulate on top of the value software chose.

Top module: `fpx_status_trap`

## Requirements
- R1: After reset `stat_o`, `ctrl_o`, `trap_req` and `trap_vec` are all zero.
- R2: A control write (`sw_we`=1, `sw_sel`=1) sets `ctrl_o` to the low 16 bits of `sw_wdata` on the next cycle. The upper bits are discarded.
- R3: A status write (`sw_we`=1, `sw_sel`=0) sets `stat_o[15:3]` to `sw_wdata[15:3]` on the next cycle. `stat_o[2:0]` always reads zero.
- R4: Datapath flags use the encoding `dp_flags[4]` invalid, `[3]` overflow, `[2]` underflow, `[1]` divide-by-zero and `[0]` inexact. Each set flag is OR'd into accrued bit 7, 6, 5, 4 or 3 respectively. Accrued bits never clear except by reset or a status write, and all-zero flags leave them unchanged.
- R5: A cause event (`cause_valid`=1, `cause_sel`=k) replaces the whole cause byte `stat_o[15:8]` with the single bit 8+k and leaves the accrued byte alone. The k encoding is: 7 branch on unordered, 6 signalling NaN, 5 operand error, 4 overflow, 3 underflow, 2 divide-by-zero, 1 inexact operation, 0 inexact decimal input. In a cycle with no cause, the cause byte holds its value.
- R6: When `dp_is_cmp`=1 and `dp_flags[4]` (invalid) is set, the operand-error cause (bit 13) is raised. An invalid flag without `dp_is_cmp` raises no cause.
- R7: A trap is requested only if the raised cause's bit 8+k is set in `ctrl_o` as it stood in the raising cycle. `trap_req` is then high for exactly the one cycle that follows.
- R8: `trap_vec` is 48 for branch on unordered, 49 for either inexact cause, 50 for divide-by-zero, 51 for underflow, 52 for operand error, 53 for overflow and 54 for signalling NaN. It is 0 whenever `trap_req` is low.
- R9: When a status write coincides with a cause event or datapath flags, the written value is kept exactly and no trap is requested.
- R10: A status write reloads the sticky flags from the written accrued bits. Later flags are OR'd onto that value, so bits written as zero stay zero until flagged again.
- R11: If a cause event and a compare-invalid occur together, the cause event decides the cause byte. The invalid flag still sets accrued bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dp_flags | input | 5 | Datapath condition flags for this cycle |
| dp_is_cmp | input | 1 | Current operation is a compare |
| cause_valid | input | 1 | A per-operation cause event is present |
| cause_sel | input | 3 | Index of the raised cause |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 1 | Write target: 0 status word, 1 control word |
| sw_wdata | input | 32 | Software write data |
| stat_o | output | 16 | Cause byte [15:8] and accrued byte [7:0] |
| ctrl_o | output | 16 | Control word; bits [15:8] are trap enables |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | 8 | Exception vector number for the trap |

## Verification
Every output of this block comes from a register. A write, a flag or a cause presented in one cycle therefore shows on `stat_o`, `ctrl_o`, `trap_req` and `trap_vec` right after the next rising edge, and the trap pulse disappears one edge later. The bench changes its inputs and samples the outputs on falling edges. Directed checks read the outputs on the falling edge that follows the capturing edge. A behavioural model steps on each rising edge and is compared with the outputs on every falling edge. This also catches a trap pulse that lasts too long, and a control write whose new enables wrongly take effect in the same cycle.

// File: rtl/fpx_pkg.sv
// Package: shared constants, cause and flag encodings, and the vector map
// for the floating-point exception status and trap unit.
package fpx_pkg;

    localparam int NCAUSE = 8;                 // causes in the cause byte
    localparam int NFLAG  = 5;                 // datapath flags / accrued bits
    localparam int CSEL_W = $clog2(NCAUSE);    // cause index width
    localparam int ES_LO  = 8;                 // lowest bit of the cause byte
    localparam int AE_LO  = 3;                 // lowest used accrued bit
    localparam int STAT_W = ES_LO + NCAUSE;    // width of the kept status field

    // Cause index k lands on status bit ES_LO+k.
    typedef enum logic [CSEL_W-1:0] {
        C_INEX_DEC = 3'd0,
        C_INEX_OP  = 3'd1,
        C_DIVZ     = 3'd2,
        C_UNDER    = 3'd3,
        C_OVER     = 3'd4,
        C_OPERR    = 3'd5,
        C_SNAN     = 3'd6,
        C_UNORD    = 3'd7
    } cause_e;

    // Flag positions; flag j lands on accrued bit AE_LO+j.
    localparam int F_INEX  = 0;
    localparam int F_DIVZ  = 1;
    localparam int F_UNDER = 2;
    localparam int F_OVER  = 3;
    localparam int F_INVAL = 4;

    // Offset of a cause's vector above the vector base; both inexact causes share one.
    function automatic int cause_vec_offset(input logic [CSEL_W-1:0] idx);
        case (idx)
            C_UNORD:    return 0;
            C_INEX_OP:  return 1;
            C_INEX_DEC: return 1;
            C_DIVZ:     return 2;
            C_UNDER:    return 3;
            C_OPERR:    return 4;
            C_OVER:     return 5;
            default:    return 6;   // C_SNAN
        endcase
    endfunction

endpackage

// File: rtl/fpx_cause_arb.sv
// Cause arbiter: decides in each cycle whether a cause is raised and which one.
// An explicit cause event has priority over the compare-invalid condition.
// A blocking status write suppresses any cause. Purely combinational.
module fpx_cause_arb
    import fpx_pkg::*;
(
    input  logic              cause_valid,
    input  logic [CSEL_W-1:0] cause_sel,
    input  logic              cmp_op,
    input  logic              inval_flag,
    input  logic              block,
    output logic              raise,
    output logic [CSEL_W-1:0] raise_idx,
    output logic [NCAUSE-1:0] raise_oh
);

    logic cmp_inval;

    // Compare that reports invalid turns into an operand-error cause.
    always_comb begin
        cmp_inval = cmp_op & inval_flag;
        raise     = ~block & (cause_valid | cmp_inval);
        raise_idx = cause_valid ? cause_sel : C_OPERR;
    end

    // One-hot image of the raised cause, one bit per cause position.
    for (genvar k = 0; k < NCAUSE; k++) begin : g_oh
        assign raise_oh[k] = raise & (raise_idx == CSEL_W'(k));
    end

endmodule

// File: rtl/fpx_accrue.sv
// Sticky flag accumulator: ORs datapath flags into a sticky register. A load
// replaces the register with software's value and ignores flags that cycle.
// Assumes the load has already been qualified as a status write.
module fpx_accrue
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flags,
    input  logic             load,
    input  logic [NFLAG-1:0] load_val,
    output logic [NFLAG-1:0] sticky
);

    // Sticky register: reset clears it, a load replaces it, flags set bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky <= '0;
        else if (load)
            sticky <= load_val;
        else
            sticky <= sticky | flags;
    end

endmodule

// File: rtl/fpx_trap_gen.sv
// Trap generator: registers a one-cycle trap request and its vector number
// when the raised cause has its enable set. It assumes the enables are the
// values in force during the raising cycle. The vector reads zero when idle.
module fpx_trap_gen
    import fpx_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise,
    input  logic [CSEL_W-1:0] raise_idx,
    input  logic [NCAUSE-1:0] enables,
    output logic              trap_req,
    output logic [VEC_W-1:0]  trap_vec
);

    logic fire;

    // Fire when the raised cause is enabled.
    always_comb fire = raise & enables[raise_idx];

    // Trap pulse and vector register; both return to zero in the next idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req <= 1'b0;
            trap_vec <= '0;
        end else begin
            trap_req <= fire;
            trap_vec <= fire ? VEC_W'(VEC_BASE + cause_vec_offset(raise_idx)) : '0;
        end
    end

endmodule

// File: rtl/fpx_status_trap.sv
// Top: floating-point exception status and trap unit. It holds the cause
// byte and the control word, and instantiates the cause arbiter, the sticky
// flag accumulator and the trap generator. A status write wins over every
// event in its cycle. A control write takes effect for later cycles only.
module fpx_status_trap
    import fpx_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CTRL_W   = 16,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAG-1:0]  dp_flags,
    input  logic              dp_is_cmp,
    input  logic              cause_valid,
    input  logic [CSEL_W-1:0] cause_sel,
    input  logic              sw_we,
    input  logic              sw_sel,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [STAT_W-1:0] stat_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              trap_req,
    output logic [VEC_W-1:0]  trap_vec
);

    logic              stat_wr;
    logic              ctrl_wr;
    logic              raise;
    logic [CSEL_W-1:0] raise_idx;
    logic [NCAUSE-1:0] raise_oh;
    logic [NCAUSE-1:0] cause_q;
    logic [NFLAG-1:0]  sticky;
    logic [CTRL_W-1:0] ctrl_q;
    logic              unused_hi;

    // Write decode for the two software targets.
    always_comb begin
        stat_wr = sw_we & ~sw_sel;
        ctrl_wr = sw_we & sw_sel;
    end

    assign unused_hi = ^sw_wdata[DATA_W-1:CTRL_W];

    fpx_cause_arb arb_i (
        .cause_valid (cause_valid),
        .cause_sel   (cause_sel),
        .cmp_op      (dp_is_cmp),
        .inval_flag  (dp_flags[F_INVAL]),
        .block       (stat_wr),
        .raise       (raise),
        .raise_idx   (raise_idx),
        .raise_oh    (raise_oh)
    );

    fpx_accrue acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (dp_flags),
        .load     (stat_wr),
        .load_val (sw_wdata[AE_LO +: NFLAG]),
        .sticky   (sticky)
    );

    fpx_trap_gen #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) trap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise     (raise),
        .raise_idx (raise_idx),
        .enables   (ctrl_q[ES_LO +: NCAUSE]),
        .trap_req  (trap_req),
        .trap_vec  (trap_vec)
    );

    // Cause byte: loaded by a status write, else replaced by a raised cause.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= '0;
        else if (stat_wr)
            cause_q <= sw_wdata[ES_LO +: NCAUSE];
        else if (raise)
            cause_q <= raise_oh;
    end

    // Control word: keeps the low CTRL_W bits of a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= sw_wdata[CTRL_W-1:0];
    end

    // Status view: cause byte, accrued bits, unused bits read zero.
    always_comb begin
        stat_o = {cause_q, sticky, {AE_LO{1'b0}}};
        ctrl_o = ctrl_q;
    end

endmodule

// File: rtl/fpx_status_trap_chk.sv
// Checker: temporal properties of the exception unit, observed at its ports.
// Attached to every instance of the top module by the bind below.
module fpx_status_trap_chk #(
    parameter int DATA_W   = 32,
    parameter int CTRL_W   = 16,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        dp_flags,
    input logic              dp_is_cmp,
    input logic              cause_valid,
    input logic [2:0]        cause_sel,
    input logic              sw_we,
    input logic              sw_sel,
    input logic [DATA_W-1:0] sw_wdata,
    input logic [15:0]       stat_o,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic              trap_req,
    input logic [VEC_W-1:0]  trap_vec
);

    logic st_wr;
    logic unused_chk;
    assign st_wr      = sw_we & ~sw_sel;
    assign unused_chk = ^{sw_wdata[DATA_W-1:16], sw_wdata[2:0]};

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_sel) |=> (ctrl_o == $past(sw_wdata[CTRL_W-1:0]))); // R2

    AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> (stat_o == {$past(sw_wdata[15:3]), 3'b000})); // R3

    AST_ACCRUED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> (($past(stat_o[7:3]) & ~stat_o[7:3]) == 5'd0)); // R4

    AST_CAUSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_valid && !st_wr) |=> (stat_o[15:8] == (8'h01 << $past(cause_sel)))); // R5

    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_valid && !(dp_is_cmp && dp_flags[4]) && !st_wr) |=> $stable(stat_o[15:8])); // R5

    AST_CMP_OPERR: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_is_cmp && dp_flags[4] && !cause_valid && !st_wr) |=> (stat_o[15:8] == 8'h20)); // R6

    AST_TRAP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (($past(ctrl_o[15:8]) & stat_o[15:8]) != 8'h00)); // R7

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (int'(trap_vec) >= VEC_BASE && int'(trap_vec) <= VEC_BASE + 6)); // R8

    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_vec == '0)); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> !trap_req); // R9

endmodule

bind fpx_status_trap fpx_status_trap_chk #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) chk_i (.*);

// File: tb/fpx_status_trap_tb_top.sv
`timescale 1ns/1ps
// Bench: directed stimulus plus a behavioural reference model stepped on
// each rising edge and compared with the outputs on every falling edge.
module fpx_status_trap_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dp_flags = '0;
    logic        dp_is_cmp = 1'b0;
    logic        cause_valid = 1'b0;
    logic [2:0]  cause_sel = '0;
    logic        sw_we = 1'b0;
    logic        sw_sel = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [15:0] stat_o;
    logic [15:0] ctrl_o;
    logic        trap_req;
    logic [7:0]  trap_vec;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;   // 250 MHz

    fpx_status_trap dut_i (
        .clk(clk), .rst_n(rst_n), .dp_flags(dp_flags), .dp_is_cmp(dp_is_cmp),
        .cause_valid(cause_valid), .cause_sel(cause_sel), .sw_we(sw_we),
        .sw_sel(sw_sel), .sw_wdata(sw_wdata), .stat_o(stat_o), .ctrl_o(ctrl_o),
        .trap_req(trap_req), .trap_vec(trap_vec)
    );

    // Vector table from the requirement, indexed by cause number.
    function automatic logic [7:0] exp_vec(input int c);
        int tab[8] = '{49, 49, 50, 51, 53, 52, 54, 48};
        return 8'(tab[c]);
    endfunction

    // Reference model state.
    logic [7:0]  m_es = '0;
    logic [4:0]  m_ae = '0;
    logic [15:0] m_ctrl = '0;
    logic        m_trap = 1'b0;
    logic [7:0]  m_vec = '0;

    // Model step: behaviour of one rising edge.
    always @(posedge clk) begin
        bit nt;
        logic [7:0] nv;
        int c;
        bit hit;
        nt = 0; nv = 0; hit = 0; c = 0;
        if (!rst_n) begin
            m_es = 0; m_ae = 0; m_ctrl = 0;
        end else begin
            if (sw_we && !sw_sel) begin
                m_es = sw_wdata[15:8];
                m_ae = sw_wdata[7:3];
            end else begin
                if (cause_valid) begin c = int'(cause_sel); hit = 1; end
                else if (dp_is_cmp && dp_flags[4]) begin c = 5; hit = 1; end
                if (hit) begin
                    m_es = 8'h01 << c;
                    if (m_ctrl[8 + c]) begin nt = 1; nv = exp_vec(c); end
                end
                m_ae = m_ae | dp_flags;
            end
            if (sw_we && sw_sel) m_ctrl = sw_wdata[15:0];
        end
        m_trap = nt;
        m_vec = nv;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Model comparison on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            chk({cur_req, " model"}, {stat_o, ctrl_o}, {m_es, m_ae, 3'b000, m_ctrl});
            chk({cur_req, " model trap"}, {23'd0, trap_req, trap_vec}, {23'd0, m_trap, m_vec});
        end
    end

    // One stimulus cycle; returns on the falling edge after the capturing edge.
    task automatic op(input logic we, input logic sel, input logic [31:0] wd,
                      input logic cv, input logic [2:0] cs, input logic cmp,
                      input logic [4:0] fl);
        @(negedge clk);
        sw_we = we; sw_sel = sel; sw_wdata = wd;
        cause_valid = cv; cause_sel = cs; dp_is_cmp = cmp; dp_flags = fl;
        @(negedge clk);
        sw_we = 0; sw_sel = 0; sw_wdata = 0;
        cause_valid = 0; cause_sel = 0; dp_is_cmp = 0; dp_flags = 0;
    endtask

    task automatic idle();
        op(0, 0, 0, 0, 0, 0, 0);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("R1 stat", {16'd0, stat_o}, 32'h0);
        chk("R1 ctrl", {16'd0, ctrl_o}, 32'h0);
        chk("R1 trap", {23'd0, trap_req, trap_vec}, 32'h0);
        rst_n = 1;
        idle();

        cur_req = "R2";
        op(1, 1, 32'h1234_A5C3, 0, 0, 0, 0);
        chk("R2 ctrl low half", {16'd0, ctrl_o}, 32'hA5C3);
        op(1, 1, 32'h0000_0000, 0, 0, 0, 0);

        cur_req = "R3";
        op(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        chk("R3 stat all ones", {16'd0, stat_o}, 32'hFFF8);
        op(1, 0, 32'h0000_0000, 0, 0, 0, 0);
        chk("R3 stat cleared", {16'd0, stat_o}, 32'h0);

        cur_req = "R4";
        op(0, 0, 0, 0, 0, 0, 5'b00001);
        chk("R4 inexact", {16'd0, stat_o}, 32'h0008);
        op(0, 0, 0, 0, 0, 0, 5'b10010);
        chk("R4 invalid+divz sticky", {16'd0, stat_o}, 32'h0098);
        op(0, 0, 0, 0, 0, 0, 5'b01100);
        chk("R4 over+under", {16'd0, stat_o}, 32'h00F8);
        idle();
        chk("R4 no flags hold", {16'd0, stat_o}, 32'h00F8);

        cur_req = "R5";
        op(0, 0, 0, 1, 3'd2, 0, 0);
        chk("R5 divz cause", {16'd0, stat_o}, 32'h04F8);
        chk("R7 disabled no trap", {31'd0, trap_req}, 32'h0);
        op(0, 0, 0, 1, 3'd7, 0, 0);
        chk("R5 unordered replaces", {16'd0, stat_o}, 32'h80F8);
        idle();
        chk("R5 hold", {16'd0, stat_o}, 32'h80F8);

        cur_req = "R6";
        op(1, 0, 32'h0, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 1, 5'b10000);
        chk("R6 compare invalid operr", {16'd0, stat_o}, 32'h2080);
        op(0, 0, 0, 1, 3'd0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 5'b10000);
        chk("R6 invalid w/o compare", {16'd0, stat_o}, 32'h0180);

        cur_req = "R8";
        op(1, 1, 32'h0000_FF00, 0, 0, 0, 0);
        for (int c = 0; c < 8; c++) begin
            op(0, 0, 0, 1, 3'(c), 0, 0);
            chk($sformatf("R8 vector cause %0d", c), {23'd0, trap_req, trap_vec},
                {23'd0, 1'b1, exp_vec(c)});
            idle();
            chk("R7 single pulse", {23'd0, trap_req, trap_vec}, 32'h0);
        end
        op(0, 0, 0, 0, 0, 1, 5'b10000);
        chk("R8 compare operr vector", {23'd0, trap_req, trap_vec}, {23'd0, 1'b1, 8'd52});

        cur_req = "R7";
        op(1, 1, 32'h0000_0400, 0, 0, 0, 0);
        op(0, 0, 0, 1, 3'd3, 0, 0);
        chk("R7 underflow masked", {23'd0, trap_req, trap_vec}, 32'h0);
        op(0, 0, 0, 1, 3'd2, 0, 0);
        chk("R7 divz enabled", {23'd0, trap_req, trap_vec}, {23'd0, 1'b1, 8'd50});
        op(1, 1, 32'h0000_FF00, 1, 3'd4, 0, 0);
        chk("R7 old enables apply", {31'd0, trap_req}, 32'h0);

        cur_req = "R9";
        op(1, 0, 32'h0000_0100, 1, 3'd7, 1, 5'b11111);
        chk("R9 write wins stat", {16'd0, stat_o}, 32'h0100);
        chk("R9 write wins trap", {31'd0, trap_req}, 32'h0);

        cur_req = "R10";
        op(1, 0, 32'h0000_0080, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 5'b00001);
        chk("R10 reload then accrue", {16'd0, stat_o}, 32'h0088);
        op(1, 0, 32'h0000_0000, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 5'b00010);
        chk("R10 cleared flags stay clear", {16'd0, stat_o}, 32'h0010);

        cur_req = "R11";
        op(1, 1, 32'h0000_0000, 0, 0, 0, 0);
        op(0, 0, 0, 1, 3'd1, 1, 5'b10000);
        chk("R11 event beats compare", {16'd0, stat_o}, 32'h0290);

        idle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule